// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block carries 36-bit words from a producer in one clock domain to a consumer in another. Writes are taken on the write clock whenever the write side reports room. The read side moves the oldest stored word into an output register on its own and holds it there until the consumer takes it. Both pointers cross between the domains as Gray codes through two-flop synchronisers. Each side therefore sees the other side's progress two of its own clock edges late.

Four status signals are produced. Write-ready and the active-low almost-full flag belong to the write clock. Read-valid and the active-low almost-empty flag belong to the read clock. The fill level that drives the flags counts only words still in the storage array. A word that has been moved into the output register is no longer counted, and its array slot is free again. The two thresholds are registers. They take preset values at reset, and each can be reloaded in parallel on the clock of the flag it controls.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is held and right after it is released, with no clock edge in between: wr_ready is 1, rd_valid is 0, rd_almost_empty_n is 0 and wr_almost_full_n is 1. The thresholds hold the presets AE_PRESET (X) and AF_PRESET (Y).
- R2: Words leave rd_data in the order they were accepted, without change. A write is accepted on a wclk edge when wr_en and wr_ready are both 1. The block holds DEPTH words in the array plus one in the output register. The binary write pointer advances by one per accepted write, and its Gray code changes by at most one bit per wclk edge.
- R3: A write attempted while wr_ready is 0 is ignored. No pointer moves, and its data never appears at rd_data.
- R4: wr_ready falls straight after the wclk edge of the write that fills the array. After a read from a full array, it rises after the second wclk edge and stays 0 before that. A write is accepted on the following edge.
- R5: rd_valid rises on the rclk edge that moves a word into the output register. This is the third rclk edge after the first write into an empty block. A read with rd_valid at 1 consumes the word, and the next word is fetched on the same edge if one is available. rd_en with rd_valid at 0 is ignored. While rd_en is 0, rd_valid and rd_data hold.
- R6: rd_almost_empty_n is 0 while the array level is X or less, and 1 at X+1 or more. After a write that raises the level to X+1, it rises after the second rclk edge.
- R7: wr_almost_full_n is 0 while the array level is DEPTH-Y or more, and 1 at DEPTH-Y-1 or less. After a read that lowers the level to DEPTH-Y-1, it rises after the second wclk edge. wr_almost_full_n is 0 whenever wr_ready is 0.
- R8: The word held in the output register is counted in neither flag's level. With the default presets, wr_almost_full_n falls with the 509th accepted write into an empty block, and wr_ready falls with the 513th.
- R9: An rclk edge with ae_ofs_ld at 1 loads ae_ofs_val into X. A wclk edge with af_ofs_ld at 1 loads af_ofs_val into Y. The affected flag uses the new value straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | WORD_W | Word to store |
| wr_ready | output | 1 | High while an array slot is free |
| wr_almost_full_n | output | 1 | Low when level >= DEPTH-Y (wclk domain) |
| af_ofs_ld | input | 1 | Load Y on wclk |
| af_ofs_val | input | clog2(DEPTH) | New value for Y |
| rd_en | input | 1 | Take the word in the output register |
| rd_data | output | WORD_W | Output register |
| rd_valid | output | 1 | Output register holds a word |
| rd_almost_empty_n | output | 1 | Low when level <= X (rclk domain) |
| ae_ofs_ld | input | 1 | Load X on rclk |
| ae_ofs_val | input | clog2(DEPTH) | New value for X |

## Verification
A stale or miscounted pointer on either side shows up at once as a flag edge in the wrong cycle. The bench pins each flag edge to an exact clock count after the operation that caused it, so an error of a single cycle is caught. A pointer that skips or repeats shows as a capacity other than DEPTH+1 or as a word out of order. Both are caught when the block is filled and drained, within about a thousand cycles. An output register that is counted in the level moves the almost-full edge by one accepted write.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int DCF_WORD_W    = 36;
    localparam int DCF_DEPTH     = 512;
    localparam int DCF_AE_PRESET = 4;
    localparam int DCF_AF_PRESET = 4;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 36
) (
    input  logic                     wclk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WORD_W-1:0]        rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
    parameter int DEPTH     = 512,
    parameter int AF_PRESET = 4
) (
    input  logic                     wclk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     af_ld,
    input  logic [$clog2(DEPTH)-1:0] af_val,
    input  logic [$clog2(DEPTH):0]   rgray_i,
    output logic                     ready,
    output logic                     af_n,
    output logic                     mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_waddr,
    output logic [$clog2(DEPTH):0]   wgray_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
        logic [AW-1:0] y;
    } wr_st_t;

    wr_st_t        st_d, st_q;
    logic [PW-1:0] rgray_s, rbin, level;
    logic [PW:0]   room;
    logic          accept;

    dcf_sync2 #(.W(PW)) u_rsync (
        .clk    (wclk),
        .rst_n  (rst_n),
        .async_i(rgray_i),
        .sync_o (rgray_s)
    );

    for (genvar g = 0; g < PW; g++) begin : g_g2b
        assign rbin[g] = ^rgray_s[PW-1:g];
    end

    always_comb begin
        level  = st_q.wptr - rbin;
        ready  = (level != PW'(DEPTH));
        room   = {1'b0, level} + {2'b00, st_q.y};
        af_n   = (room < (PW+1)'(DEPTH));
        accept = wr_en && ready;
        st_d       = st_q;
        st_d.y     = af_ld ? af_val : st_q.y;
        st_d.wptr  = st_q.wptr + PW'(accept);
        st_d.wgray = st_d.wptr ^ (st_d.wptr >> 1);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wptr: '0, wgray: '0, y: AW'(AF_PRESET)};
        else        st_q <= st_d;
    end

    assign mem_we    = accept;
    assign mem_waddr = st_q.wptr[AW-1:0];
    assign wgray_o   = st_q.wgray;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
    parameter int DEPTH     = 512,
    parameter int WORD_W    = 36,
    parameter int AE_PRESET = 4
) (
    input  logic                     rclk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic                     ae_ld,
    input  logic [$clog2(DEPTH)-1:0] ae_val,
    input  logic [$clog2(DEPTH):0]   wgray_i,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic [$clog2(DEPTH)-1:0] mem_raddr,
    output logic [$clog2(DEPTH):0]   rgray_o,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     ae_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0]     rptr;
        logic [PW-1:0]     rgray;
        logic [WORD_W-1:0] dout;
        logic              valid;
        logic [AW-1:0]     x;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [PW-1:0] wgray_s, wbin, level;
    logic          take, fetch;

    dcf_sync2 #(.W(PW)) u_wsync (
        .clk    (rclk),
        .rst_n  (rst_n),
        .async_i(wgray_i),
        .sync_o (wgray_s)
    );

    for (genvar g = 0; g < PW; g++) begin : g_g2b
        assign wbin[g] = ^wgray_s[PW-1:g];
    end

    always_comb begin
        level = wbin - st_q.rptr;
        ae_n  = (level > {1'b0, st_q.x});
        take  = rd_en && st_q.valid;
        fetch = (level != '0) && (!st_q.valid || take);
        st_d   = st_q;
        st_d.x = ae_ld ? ae_val : st_q.x;
        if (fetch) begin
            st_d.rptr  = st_q.rptr + PW'(1);
            st_d.dout  = mem_rdata;
            st_d.valid = 1'b1;
        end else if (take) begin
            st_d.valid = 1'b0;
        end
        st_d.rgray = st_d.rptr ^ (st_d.rptr >> 1);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rptr: '0, rgray: '0, dout: '0, valid: 1'b0, x: AW'(AE_PRESET)};
        else        st_q <= st_d;
    end

    assign mem_raddr = st_q.rptr[AW-1:0];
    assign rgray_o   = st_q.rgray;
    assign rd_data   = st_q.dout;
    assign rd_valid  = st_q.valid;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH     = DCF_DEPTH,
    parameter int WORD_W    = DCF_WORD_W,
    parameter int AE_PRESET = DCF_AE_PRESET,
    parameter int AF_PRESET = DCF_AF_PRESET
) (
    input  logic                     wclk,
    input  logic                     rclk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_data,
    output logic                     wr_ready,
    output logic                     wr_almost_full_n,
    input  logic                     af_ofs_ld,
    input  logic [$clog2(DEPTH)-1:0] af_ofs_val,
    input  logic                     rd_en,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     rd_almost_empty_n,
    input  logic                     ae_ofs_ld,
    input  logic [$clog2(DEPTH)-1:0] ae_ofs_val
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0]     w_gray, r_gray;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr;
    logic [WORD_W-1:0] mem_rdata;

    dcf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .wclk (wclk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(wr_data),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    dcf_wr_side #(.DEPTH(DEPTH), .AF_PRESET(AF_PRESET)) u_wr (
        .wclk     (wclk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .af_ld    (af_ofs_ld),
        .af_val   (af_ofs_val),
        .rgray_i  (r_gray),
        .ready    (wr_ready),
        .af_n     (wr_almost_full_n),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr),
        .wgray_o  (w_gray)
    );

    dcf_rd_side #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AE_PRESET(AE_PRESET)) u_rd (
        .rclk     (rclk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .ae_ld    (ae_ofs_ld),
        .ae_val   (ae_ofs_val),
        .wgray_i  (w_gray),
        .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr),
        .rgray_o  (r_gray),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .ae_n     (rd_almost_empty_n)
    );
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int WORD_W = 36,
    parameter int PW     = 10
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_ready,
    input logic              wr_almost_full_n,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              rd_almost_empty_n,
    input logic [WORD_W-1:0] rd_data,
    input logic [PW-1:0]     w_gray
);
    // R3
    wr_ignore_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(w_gray));

    // R2
    gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(w_gray ^ $past(w_gray)));

    // R7
    full_af_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_ready |-> !wr_almost_full_n);

    // R5
    out_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    // R6
    ae_fetch_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_almost_empty_n && !rd_valid) |=> rd_valid);
endmodule

bind dcf_fifo dcf_fifo_chk #(.WORD_W(WORD_W), .PW(PW)) u_chk (
    .wclk             (wclk),
    .rclk             (rclk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_ready         (wr_ready),
    .wr_almost_full_n (wr_almost_full_n),
    .rd_en            (rd_en),
    .rd_valid         (rd_valid),
    .rd_almost_empty_n(rd_almost_empty_n),
    .rd_data          (rd_data),
    .w_gray           (w_gray)
);

// File: tb/test_dcf_fifo.sv
`timescale 1ns/1ps
module test_dcf_fifo;
    localparam int DEPTH = 512;
    localparam int WW    = 36;
    localparam int AW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          af_ofs_ld = 1'b0, ae_ofs_ld = 1'b0;
    logic [AW-1:0] af_ofs_val = '0, ae_ofs_val = '0;
    logic          wr_ready, wr_almost_full_n, rd_valid, rd_almost_empty_n;
    logic [WW-1:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dcf_fifo #(.DEPTH(DEPTH), .WORD_W(WW), .AE_PRESET(4), .AF_PRESET(4)) i_dcf_fifo (
        .wclk(clk), .rclk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .wr_almost_full_n(wr_almost_full_n),
        .af_ofs_ld(af_ofs_ld), .af_ofs_val(af_ofs_val),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_almost_empty_n(rd_almost_empty_n),
        .ae_ofs_ld(ae_ofs_ld), .ae_ofs_val(ae_ofs_val)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [WW-1:0] wd, input logic re);
        wr_en = we; wr_data = wd; rd_en = re;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // row: [8] we, [7] re, [6] expected rd_valid, [5] expected ae_n, [4] check data, [3:0] word index
    localparam logic [8:0] TBL [19] = '{
        9'b1_0_0_0_0_0000, 9'b1_0_0_0_0_0000, 9'b1_0_0_0_0_0000,
        9'b1_0_1_0_1_0000, 9'b1_0_1_0_1_0000, 9'b1_0_1_0_1_0000,
        9'b1_0_1_0_1_0000, 9'b1_0_1_1_1_0000, 9'b0_0_1_1_1_0000,
        9'b0_0_1_1_1_0000, 9'b0_1_1_1_1_0001, 9'b0_1_1_1_1_0010,
        9'b0_1_1_0_1_0011, 9'b0_1_1_0_1_0100, 9'b0_1_1_0_1_0101,
        9'b0_1_1_0_1_0110, 9'b0_1_1_0_1_0111, 9'b0_1_0_0_0_0000,
        9'b0_1_0_0_0_0000
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        int widx;
        int acc;
        int af_at;
        int nexp;
        int mism;
        int dead;
        logic [8:0] v;
        logic rdy;

        repeat (3) @(negedge clk);
        // R1 reset state while held
        chk("R1 ready in reset", wr_ready, 1);
        chk("R1 valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        chk("R1 ae_n after reset", rd_almost_empty_n, 0);
        chk("R1 af_n after reset", wr_almost_full_n, 1);

        // R5 R6 table walk with preset X = 4
        widx = 0;
        for (int k = 0; k < 19; k++) begin
            v = TBL[k];
            step(v[8], WW'(36'h100 + widx), v[7]);
            if (v[8]) widx++;
            chk($sformatf("R5 valid row %0d", k), rd_valid, v[6]);
            chk($sformatf("R6 ae_n row %0d", k), rd_almost_empty_n, v[5]);
            if (v[4]) chk($sformatf("R2 data row %0d", k), rd_data, 36'h100 + v[3:0]);
        end
        repeat (4) step(1'b0, '0, 1'b0);

        // R2 R8 fill to capacity; attempts while not ready carry a marker word
        acc = 0; af_at = -1;
        for (int i = 0; i < 530; i++) begin
            rdy = wr_ready;
            step(1'b1, rdy ? WW'(36'h1000 + acc) : 36'hDEAD, 1'b0);
            if (rdy) acc++;
            if (!wr_almost_full_n && af_at < 0) af_at = acc;
        end
        chk("R2 capacity DEPTH+1", acc, 513);
        chk("R8 af_n falls at accepted write", af_at, 509);
        chk("R4 ready low when full", wr_ready, 0);
        chk("R7 af_n low when full", wr_almost_full_n, 0);

        // R4 ready recovery two edges after a read
        step(1'b0, '0, 1'b1);
        chk("R4 ready after read edge", wr_ready, 0);
        step(1'b0, '0, 1'b0);
        chk("R4 ready one edge later", wr_ready, 0);
        step(1'b0, '0, 1'b0);
        chk("R4 ready second edge", wr_ready, 1);
        step(1'b1, WW'(36'h1000 + 513), 1'b0);
        chk("R4 write accepted then full", wr_ready, 0);

        // R7 almost-full recovery: five reads bring the level to DEPTH-Y-1
        repeat (5) step(1'b0, '0, 1'b1);
        step(1'b0, '0, 1'b0);
        chk("R7 af_n one edge after last read", wr_almost_full_n, 0);
        step(1'b0, '0, 1'b0);
        chk("R7 af_n second edge", wr_almost_full_n, 1);

        // R2 R3 drain and check order, count and absence of the marker
        nexp = 6; mism = 0; dead = 0;
        for (int i = 0; i < 700; i++) begin
            if (rd_valid) begin
                if (rd_data == 36'hDEAD) dead++;
                else if (rd_data != WW'(36'h1000 + nexp)) mism++;
                nexp++;
                step(1'b0, '0, 1'b1);
            end else begin
                step(1'b0, '0, 1'b0);
            end
        end
        chk("R2 drain order mismatches", mism, 0);
        chk("R2 total words delivered", nexp, 514);
        chk("R3 ignored write never read", dead, 0);

        // R9 load X = 0 on rclk, then one write
        ae_ofs_ld = 1'b1; ae_ofs_val = '0;
        step(1'b0, '0, 1'b0);
        ae_ofs_ld = 1'b0;
        step(1'b1, 36'h777, 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R6 ae_n one edge after write", rd_almost_empty_n, 0);
        step(1'b0, '0, 1'b0);
        chk("R9 ae_n with new X second edge", rd_almost_empty_n, 1);
        step(1'b0, '0, 1'b0);
        chk("R8 ae_n after fetch to output", rd_almost_empty_n, 0);
        chk("R5 valid third edge", rd_valid, 1);
        chk("R5 fetched data", rd_data, 36'h777);
        step(1'b0, '0, 1'b1);
        repeat (4) step(1'b0, '0, 1'b0);

        // R9 load Y = DEPTH-1 on wclk
        af_ofs_ld = 1'b1; af_ofs_val = AW'(DEPTH - 1);
        step(1'b0, '0, 1'b0);
        af_ofs_ld = 1'b0;
        chk("R9 af_n empty with new Y", wr_almost_full_n, 1);
        step(1'b1, 36'h888, 1'b0);
        chk("R9 af_n after one write with new Y", wr_almost_full_n, 0);

        summary();
    end
endmodule